// File: doc/BRIEF.md
# FIFO Almost-Empty / Almost-Full Threshold Register Loader

This block keeps the two threshold words that a FIFO's programmable flag logic compares against: an almost-empty threshold and an almost-full threshold, each `OFS_W` bits wide. `OFS_W` is log2 of the FIFO depth. After reset both thresholds hold a default of 127 and both are marked valid.

Software or a host can load the thresholds in two ways, chosen by the static `ser_mode` input. In serial mode one bit arrives per clock on `ser_bit`. In parallel mode whole slices arrive on the data bus `wdata`. The static `bus_sel` input sets the slice size for x36, x18 or x9 buses. Parallel loading uses a write pointer that moves through the slices in a fixed cyclic order. Readback uses its own read pointer that moves through the same order. Either sequence can be paused and resumed at any point.

Both pointers and the serial bit position run on one clock, `clk`. The readback stream has no back-pressure. While `rd_vld` is high, `rd_data` carries a slice, and the consumer must take it in that cycle. The loaded values and their valid flags go straight to the flag comparators.

Top module: `ofs_loader`

## Requirements
- R1: On an active-low `rst_n`, both thresholds become 127 and both valid flags become 1. `rd_vld` and `clash` become 0. The write pointer, read pointer and serial bit position all return to the first slot, which is the almost-empty low slice and serial bit 0.
- R2: In serial mode (`ser_mode`=1), bit k of the stream sets almost-empty bit k for k < OFS_W, and almost-full bit k-OFS_W otherwise. The stream is 2*OFS_W bits long in total. The first bit of a stream clears both valid flags. The last bit sets both. Each change is visible in the cycle after the capturing edge.
- R3: A serial bit is captured only on an edge where `ser_mode`, `load_en` and `ser_en` are all 1. On any other edge, the bit position and both thresholds hold.
- R4: For `bus_sel`=2'b00 (x36), a parallel write takes `wdata[OFS_W-1:0]` as a whole register. The write target alternates almost-empty, almost-full, almost-empty, and so on.
- R5: For `bus_sel`=2'b01 (x18), the slice width is S=ceil(OFS_W/2), taken from `wdata[S-1:0]`. The order is almost-empty low, almost-empty high, almost-full low, almost-full high, and then it wraps. Slice p fills bits [p*S +: S], truncated to OFS_W.
- R6: For `bus_sel`=2'b10 or 2'b11 (x9), the slice width is S=ceil(OFS_W/3), taken from `wdata[S-1:0]`. There are three slices per register, six writes in total, and the order then wraps.
- R7: In parallel mode, writing the first slice of a register clears that register's valid flag. Writing its last slice sets the flag. At x36 the flag stays 1.
- R8: A parallel write happens only on an edge where `ser_mode`=0, `load_en`=1 and `wr_en`=1. On any other edge, the thresholds and the write pointer are unchanged.
- R9: A readback happens on an edge where `load_en`=1 and `rd_en`=1, in either mode. In the next cycle, `rd_data` holds the slice at the read pointer, zero-extended and taken from the value before that edge, and `rd_vld` is 1. With no readback, `rd_vld` is 0, `rd_data` holds, and the read pointer holds.
- R10: On an edge where `ser_mode`=0 and `load_en`, `wr_en` and `rd_en` are all 1, both the read and the write are carried out, and `clash` is 1 in the next cycle. Otherwise `clash` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all loader state |
| rst_n | input | 1 | Active-low synchronous master reset |
| ser_mode | input | 1 | Static: 1 selects serial loading, 0 selects parallel |
| bus_sel | input | 2 | Static bus width: 00 x36, 01 x18, 10/11 x9 |
| load_en | input | 1 | Directs write, read and serial strobes to the threshold registers |
| wr_en | input | 1 | Parallel write strobe |
| ser_en | input | 1 | Serial capture strobe |
| ser_bit | input | 1 | Serial data bit |
| wdata | input | BUS_W | Parallel write data |
| rd_en | input | 1 | Readback strobe |
| ae_thr | output | OFS_W | Almost-empty threshold |
| af_thr | output | OFS_W | Almost-full threshold |
| ae_ok | output | 1 | Almost-empty threshold valid |
| af_ok | output | 1 | Almost-full threshold valid |
| rd_data | output | BUS_W | Readback slice, zero-extended |
| rd_vld | output | 1 | rd_data carries a slice this cycle |
| clash | output | 1 | A read and a write hit the registers on the previous edge |

## Verification
The bench builds the block with OFS_W=10 and BUS_W=36. With OFS_W=10, the x18 slice is 5 bits and the x9 slices are 4, 4 and 2 bits, so the short, truncated top slice is exercised. The serial stream is 20 bits long, short enough that it can be paused partway into the almost-full half. With the default of 127 set at reset, every slice write produces a visible merge with the old contents.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  typedef enum logic [1:0] {
    BW36 = 2'b00,
    BW18 = 2'b01,
    BW9  = 2'b10,
    BW9B = 2'b11
  } bus_w_e;

  // number of slices one threshold register occupies for a bus width
  function automatic int slices_per_reg(input logic [1:0] bsel);
    case (bsel)
      2'b00:   return 1;
      2'b01:   return 2;
      default: return 3;
    endcase
  endfunction

endpackage

// File: rtl/ofs_ptr.sv
// Cyclic slice pointer: steps 0..(2*slices-1) and wraps.
module ofs_ptr #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [1:0]    bus_sel,
  output logic [PW-1:0] ptr
);
  import ofs_pkg::*;

  logic [PW-1:0] last;

  always_comb last = PW'(2 * slices_per_reg(bus_sel) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)        ptr <= '0;
    else if (step)     ptr <= (ptr == last) ? '0 : ptr + 1'b1;
  end

  p_ptr_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= 3'(5));
  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(ptr));
  p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ptr == last) |=> ptr == '0);

endmodule

// File: rtl/ofs_slice_map.sv
// Maps a pointer value to target register, slice mask and shift.
module ofs_slice_map #(
  parameter int N  = 10,
  parameter int PW = 3
) (
  input  logic [1:0]    bus_sel,
  input  logic [PW-1:0] ptr,
  output logic          hi_reg,
  output logic          first,
  output logic          last,
  output logic [7:0]    shamt,
  output logic [N-1:0]  mask
);
  import ofs_pkg::*;

  localparam int S18 = (N + 1) / 2;
  localparam int S9  = (N + 2) / 3;
  localparam logic [N-1:0] M18 = N'((64'd1 << S18) - 64'd1);
  localparam logic [N-1:0] M9  = N'((64'd1 << S9) - 64'd1);

  logic [1:0] part;
  logic [2:0] spr;

  always_comb begin
    spr    = 3'(slices_per_reg(bus_sel));
    hi_reg = ({1'b0, ptr} >= {1'b0, PW'(spr)});
    part   = hi_reg ? 2'(ptr - PW'(spr)) : 2'(ptr);
    first  = (part == 2'd0);
    last   = ({1'b0, part} == spr - 3'd1);
    case (bus_sel)
      2'b00: begin
        shamt = 8'd0;
        mask  = '1;
      end
      2'b01: begin
        shamt = 8'(int'(part) * S18);
        mask  = M18 << shamt;
      end
      default: begin
        shamt = 8'(int'(part) * S9);
        mask  = M9 << shamt;
      end
    endcase
  end

endmodule

// File: rtl/ofs_ser_cnt.sv
// Serial bit position counter over the 2*N-bit stream.
module ofs_ser_cnt #(
  parameter int N = 10,
  localparam int CW = $clog2(2 * N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  output logic [CW-1:0] idx,
  output logic          first,
  output logic          last
);
  localparam logic [CW-1:0] LAST_IDX = CW'(2 * N - 1);

  assign first = (idx == '0);
  assign last  = (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n)   idx <= '0;
    else if (cap) idx <= last ? '0 : idx + 1'b1;
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST_IDX);
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(idx));

endmodule

// File: rtl/ofs_bank.sv
// The two threshold registers and their valid flags.
module ofs_bank #(
  parameter int N       = 10,
  parameter int RST_VAL = 127,
  localparam int CW = $clog2(2 * N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          par_we,
  input  logic          wr_hi,
  input  logic          wr_first,
  input  logic          wr_last,
  input  logic [N-1:0]  wr_mask,
  input  logic [N-1:0]  wr_val,
  input  logic          ser_we,
  input  logic [CW-1:0] ser_idx,
  input  logic          ser_first,
  input  logic          ser_last,
  input  logic          ser_bit,
  output logic [N-1:0]  ae_thr,
  output logic [N-1:0]  af_thr,
  output logic          ae_ok,
  output logic          af_ok
);
  logic [CW-1:0] af_idx;
  logic          in_ae;

  assign in_ae  = (ser_idx < CW'(N));
  assign af_idx = ser_idx - CW'(N);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ae_thr <= N'(RST_VAL);
      af_thr <= N'(RST_VAL);
      ae_ok  <= 1'b1;
      af_ok  <= 1'b1;
    end else if (ser_we) begin
      if (in_ae) ae_thr[ser_idx] <= ser_bit;
      else       af_thr[af_idx]  <= ser_bit;
      if (ser_first) begin
        ae_ok <= 1'b0;
        af_ok <= 1'b0;
      end
      if (ser_last) begin
        ae_ok <= 1'b1;
        af_ok <= 1'b1;
      end
    end else if (par_we) begin
      if (wr_hi) begin
        af_thr <= (af_thr & ~wr_mask) | (wr_val & wr_mask);
        if (wr_first) af_ok <= 1'b0;
        if (wr_last)  af_ok <= 1'b1;
      end else begin
        ae_thr <= (ae_thr & ~wr_mask) | (wr_val & wr_mask);
        if (wr_first) ae_ok <= 1'b0;
        if (wr_last)  ae_ok <= 1'b1;
      end
    end
  end

  p_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(par_we || ser_we) |=> ($stable(ae_thr) && $stable(af_thr)));
  p_ser_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_we && ser_first) |=> (!ae_ok && !af_ok));
  p_par_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (par_we && !ser_we && wr_last && !wr_hi) |=> ae_ok);

endmodule

// File: rtl/ofs_loader.sv
// Threshold loader top: serial / parallel load, parallel readback.
module ofs_loader #(
  parameter int OFS_W   = 10,
  parameter int BUS_W   = 36,
  parameter int RST_VAL = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_mode,
  input  logic [1:0]       bus_sel,
  input  logic             load_en,
  input  logic             wr_en,
  input  logic             ser_en,
  input  logic             ser_bit,
  input  logic [BUS_W-1:0] wdata,
  input  logic             rd_en,
  output logic [OFS_W-1:0] ae_thr,
  output logic [OFS_W-1:0] af_thr,
  output logic             ae_ok,
  output logic             af_ok,
  output logic [BUS_W-1:0] rd_data,
  output logic             rd_vld,
  output logic             clash
);
  localparam int PW  = 3;
  localparam int CW  = $clog2(2 * OFS_W);
  localparam int S18 = (OFS_W + 1) / 2;
  localparam int S9  = (OFS_W + 2) / 3;

  logic wr_req, rd_req, ser_cap;
  assign wr_req  = !ser_mode && load_en && wr_en;
  assign rd_req  = load_en && rd_en;
  assign ser_cap = ser_mode && load_en && ser_en;

  // pointers: write side and read side, same cyclic order
  logic [PW-1:0] wptr, rptr;

  ofs_ptr #(.PW(PW)) wptr_i (
    .clk(clk), .rst_n(rst_n), .step(wr_req), .bus_sel(bus_sel), .ptr(wptr));
  ofs_ptr #(.PW(PW)) rptr_i (
    .clk(clk), .rst_n(rst_n), .step(rd_req), .bus_sel(bus_sel), .ptr(rptr));

  logic             w_hi, w_first, w_last, r_hi, r_first, r_last;
  logic [7:0]       w_sh, r_sh;
  logic [OFS_W-1:0] w_mask, r_mask;

  ofs_slice_map #(.N(OFS_W), .PW(PW)) wmap_i (
    .bus_sel(bus_sel), .ptr(wptr), .hi_reg(w_hi), .first(w_first),
    .last(w_last), .shamt(w_sh), .mask(w_mask));
  ofs_slice_map #(.N(OFS_W), .PW(PW)) rmap_i (
    .bus_sel(bus_sel), .ptr(rptr), .hi_reg(r_hi), .first(r_first),
    .last(r_last), .shamt(r_sh), .mask(r_mask));

  // serial bit position
  logic [CW-1:0] s_idx;
  logic          s_first, s_last;

  ofs_ser_cnt #(.N(OFS_W)) scnt_i (
    .clk(clk), .rst_n(rst_n), .cap(ser_cap), .idx(s_idx),
    .first(s_first), .last(s_last));

  // write data field, aligned onto its slice
  logic [OFS_W-1:0] fld, w_val;

  always_comb begin
    case (bus_sel)
      2'b00:   fld = wdata[OFS_W-1:0];
      2'b01:   fld = OFS_W'(wdata[S18-1:0]);
      default: fld = OFS_W'(wdata[S9-1:0]);
    endcase
    w_val = fld << w_sh;
  end

  ofs_bank #(.N(OFS_W), .RST_VAL(RST_VAL)) bank_i (
    .clk(clk), .rst_n(rst_n),
    .par_we(wr_req), .wr_hi(w_hi), .wr_first(w_first), .wr_last(w_last),
    .wr_mask(w_mask), .wr_val(w_val),
    .ser_we(ser_cap), .ser_idx(s_idx), .ser_first(s_first),
    .ser_last(s_last), .ser_bit(ser_bit),
    .ae_thr(ae_thr), .af_thr(af_thr), .ae_ok(ae_ok), .af_ok(af_ok));

  // readback: slice of the pre-edge register value, zero-extended
  logic [OFS_W-1:0] r_src, r_slice;
  logic             r_unused;

  assign r_src    = r_hi ? af_thr : ae_thr;
  assign r_slice  = (r_src & r_mask) >> r_sh;
  assign r_unused = r_first ^ r_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_vld  <= 1'b0;
      clash   <= 1'b0;
    end else begin
      rd_vld <= rd_req;
      clash  <= wr_req && rd_en;
      if (rd_req) rd_data <= BUS_W'(r_slice);
    end
  end

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> (!rd_vld && $stable(rd_data)));
  p_ser_par_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ser_mode |=> $stable(wptr));

endmodule

// File: tb/ofs_loader_tb.sv
`timescale 1ns/1ps
module ofs_loader_tb_top;
  localparam int N = 10;
  localparam int BW = 36;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ser_mode, load_en, wr_en, ser_en, ser_bit, rd_en;
  logic [1:0]    bus_sel;
  logic [BW-1:0] wdata;
  logic [N-1:0]  ae_thr, af_thr;
  logic          ae_ok, af_ok, rd_vld, clash;
  logic [BW-1:0] rd_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  ofs_loader #(.OFS_W(N), .BUS_W(BW), .RST_VAL(127)) dut_i (
    .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .bus_sel(bus_sel),
    .load_en(load_en), .wr_en(wr_en), .ser_en(ser_en), .ser_bit(ser_bit),
    .wdata(wdata), .rd_en(rd_en), .ae_thr(ae_thr), .af_thr(af_thr),
    .ae_ok(ae_ok), .af_ok(af_ok), .rd_data(rd_data), .rd_vld(rd_vld),
    .clash(clash));

  // vector: bus(2) data(9) exp_ae(10) exp_af(10) {ae_ok,af_ok}(2)
  localparam int NV = 11;
  localparam logic [32:0] VEC [NV] = '{
    {2'b01, 9'h015, 10'h075, 10'h07F, 2'b01},
    {2'b01, 9'h00A, 10'h155, 10'h07F, 2'b11},
    {2'b01, 9'h01F, 10'h155, 10'h07F, 2'b10},
    {2'b01, 9'h011, 10'h155, 10'h23F, 2'b11},
    {2'b10, 9'h00C, 10'h15C, 10'h23F, 2'b01},
    {2'b10, 9'h1A3, 10'h13C, 10'h23F, 2'b01},
    {2'b10, 9'h1FF, 10'h33C, 10'h23F, 2'b11},
    {2'b10, 9'h005, 10'h33C, 10'h235, 2'b10},
    {2'b10, 9'h009, 10'h33C, 10'h295, 2'b10},
    {2'b10, 9'h001, 10'h33C, 10'h195, 2'b11},
    {2'b10, 9'h000, 10'h330, 10'h195, 2'b01}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [BW-1:0] act,
                     input logic [BW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    load_en = 0; wr_en = 0; ser_en = 0; rd_en = 0; ser_bit = 0; wdata = '0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  task automatic pwrite(input logic [BW-1:0] v);
    load_en = 1; wr_en = 1; wdata = v;
    tick();
    idle();
  endtask

  task automatic pread(input string tag, input logic [BW-1:0] exp);
    load_en = 1; rd_en = 1;
    tick();
    idle();
    chk({tag, " rd_vld"}, BW'(rd_vld), BW'(1));
    chk(tag, rd_data, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [2*N-1:0] sv;
    ser_mode = 0; bus_sel = 2'b00;
    do_reset();

    // R1: reset state
    chk("R1 ae_thr", BW'(ae_thr), BW'(127));
    chk("R1 af_thr", BW'(af_thr), BW'(127));
    chk("R1 oks", BW'({ae_ok, af_ok}), BW'(2'b11));
    chk("R1 rd_vld/clash", BW'({rd_vld, clash}), BW'(0));

    // R5/R6/R7: table of parallel slice writes at x18 then x9
    for (int i = 0; i < NV; i++) begin
      bus_sel = VEC[i][32:31];
      pwrite(BW'(VEC[i][30:22]));
      chk($sformatf("R5/R6 vec%0d ae", i), BW'(ae_thr), BW'(VEC[i][21:12]));
      chk($sformatf("R5/R6 vec%0d af", i), BW'(af_thr), BW'(VEC[i][11:2]));
      chk($sformatf("R7 vec%0d oks", i), BW'({ae_ok, af_ok}), BW'(VEC[i][1:0]));
    end

    // R9: x9 readback with a pause, then wrap
    pread("R9 rd ae p0", BW'(0));
    pread("R9 rd ae p1", BW'(3));
    rd_en = 0; load_en = 1;
    tick();
    chk("R9 pause rd_vld", BW'(rd_vld), BW'(0));
    chk("R9 pause rd_data", rd_data, BW'(3));
    idle();
    pread("R9 rd ae p2", BW'(3));
    pread("R9 rd af p0", BW'(5));
    pread("R9 rd af p1", BW'(9));
    pread("R9 rd af p2", BW'(1));
    pread("R9 rd wrap", BW'(0));

    // R8: writes ignored without full qualification (wptr at ae p1)
    load_en = 0; wr_en = 1; wdata = 36'hF;
    tick(); idle();
    chk("R8 no load", BW'(ae_thr), BW'(10'h330));
    load_en = 1; wr_en = 0; wdata = 36'hF;
    tick(); idle();
    chk("R8 no wr_en", BW'(ae_thr), BW'(10'h330));
    ser_mode = 1; load_en = 1; wr_en = 1; wdata = 36'hF;
    tick(); idle(); ser_mode = 0;
    chk("R8 serial mode", BW'({ae_thr, af_thr}), BW'({10'h330, 10'h195}));
    pwrite(36'hE);
    chk("R8 ptr held", BW'(ae_thr), BW'(10'h3E0));

    // R1/R10: reset, then simultaneous read and write at x36
    bus_sel = 2'b00;
    do_reset();
    chk("R1 re-reset", BW'({ae_thr, af_thr}), BW'({10'd127, 10'd127}));
    load_en = 1; wr_en = 1; rd_en = 1; wdata = 36'h2AA;
    tick(); idle();
    chk("R10 clash", BW'(clash), BW'(1));
    chk("R10 rd old value", rd_data, BW'(127));
    chk("R10 ae written", BW'(ae_thr), BW'(10'h2AA));
    tick();
    chk("R10 clash clears", BW'(clash), BW'(0));

    // R4: x36 alternation, upper bus bits dropped
    pwrite(36'hF_FFFF_F0C5);
    chk("R4 af", BW'(af_thr), BW'(10'h0C5));
    pwrite(36'h011);
    chk("R4 ae again", BW'(ae_thr), BW'(10'h011));
    chk("R7 x36 oks", BW'({ae_ok, af_ok}), BW'(2'b11));
    pread("R9 x36 af", BW'(10'h0C5));
    pread("R9 x36 ae", BW'(10'h011));

    // R2/R3: serial stream with pauses
    do_reset();
    ser_mode = 1;
    sv = {10'h1CA, 10'h2B5};
    for (int k = 0; k < 2 * N; k++) begin
      if (k == 12) begin
        load_en = 1; ser_en = 0; ser_bit = ~sv[k];
        tick(); tick();
        load_en = 0; ser_en = 1;
        tick(); idle();
        chk("R3 paused af", BW'(af_thr), BW'(10'h07E));
        chk("R3 paused ae", BW'(ae_thr), BW'(10'h2B5));
      end
      load_en = 1; ser_en = 1; ser_bit = sv[k];
      tick(); idle();
      if (k == 0) chk("R2 first bit clears oks", BW'({ae_ok, af_ok}), BW'(0));
      if (k == N - 1) begin
        chk("R2 ae after N bits", BW'(ae_thr), BW'(10'h2B5));
        chk("R2 oks still low", BW'({ae_ok, af_ok}), BW'(0));
      end
    end
    chk("R2 af done", BW'(af_thr), BW'(10'h1CA));
    chk("R2 ae done", BW'(ae_thr), BW'(10'h2B5));
    chk("R2 oks set", BW'({ae_ok, af_ok}), BW'(2'b11));
    load_en = 1; ser_en = 1; ser_bit = 0;
    tick(); idle();
    chk("R2 restart clears oks", BW'({ae_ok, af_ok}), BW'(0));
    chk("R2 restart bit0", BW'(ae_thr), BW'(10'h2B4));
    pread("R9 serial readback", BW'(10'h2B4));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule